// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Lock Detector

This block is the digital side of an integer-N frequency synthesizer. It takes a reference clock and an oscillator clock, both sampled as levels by a fast system clock. It divides each one down, compares the two divided edge streams in a phase-frequency detector, and decides whether the loop is locked. The reference path can count both edges of the reference instead of only rising ones, which doubles the reference rate. The reference divider then produces pulses at reference/R. The main divider produces pulses at oscillator/N, so in lock the oscillator runs at reference × N / R.

The main divider is built the way a dual-modulus synthesizer builds it. A prescaler divides by M or M+1, where M = 2^PSC_W (64/65 by default). A program counter counts P prescaler cycles, and a swallow counter selects M+1 for the first A of those cycles. The up and down outputs are meant for an external charge pump. A single output pin shows one of four sources, chosen by a 2-bit test select: the lock flag, either divider's output pulse, or a forced low. A change to either divide ratio restarts both dividers and drops lock.

Top module: `intn_div_lock`

## Requirements
- R1: With the main ratio N split as P = N[N_W-1:PSC_W] and A = N[PSC_W-1:0], the main divider emits exactly one pulse per N oscillator rising edges. It divides by M+1 for the first A prescaler cycles and by M for the other P-A. This is valid when P ≥ M-1 and P ≥ A; with the default 16-bit ratio and 64/65 prescaler, that means N from 4032 to 65535.
- R2: The reference divider emits one pulse per R reference ticks, where R is ref_ratio_i (9 bits, valid from 8 to 511, reset value 80).
- R3: When dbl_en_i = 0, only rising edges of ref_i are reference ticks. When dbl_en_i = 1, both rising and falling edges are ticks.
- R4: The detector raises up_o on a reference pulse and dn_o on a main pulse. Both clear as soon as both pulses have arrived, so pulses that arrive in the same cycle raise neither. up_o and dn_o are never high together.
- R5: Lock is declared after LOCK_CNT consecutive comparisons (default 16) in which the open detector pulse is shorter than LOCK_WIN fast-clock cycles. Lock is not declared after LOCK_CNT-1 such comparisons.
- R6: Lock is cleared as soon as an open detector pulse reaches LOCK_WIN cycles, even when no ratio has changed.
- R7: Any change of main_ratio_i or ref_ratio_i restarts both dividers and the detector from zero and clears lock. lock_o is low within two cycles of the change.
- R8: tst_sel_i selects the source of lock_o, registered one cycle: 00 the lock flag, 01 the main divider pulse, 10 the reference divider pulse, 11 constant low.
- R9: During and after reset, lock_o, up_o and dn_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock level |
| osc_i | input | 1 | Oscillator clock level |
| dbl_en_i | input | 1 | Count both reference edges |
| main_ratio_i | input | N_W | Main divide ratio N |
| ref_ratio_i | input | R_W | Reference divide ratio R |
| tst_sel_i | input | 2 | Lock pin source select |
| up_o | output | 1 | Detector up pulse |
| dn_o | output | 1 | Detector down pulse |
| lock_o | output | 1 | Lock flag or selected test source |

## Verification
The bench builds the block with PSC_W = 2, which gives a 4/5 prescaler, and LOCK_WIN = 4. With these values the smallest valid N is 12, so a full comparison cycle takes a few dozen fast cycles, and sixteen comparisons fit easily in a short run. The same waveform drives both clock inputs. For matched ratios the divided edges then coincide exactly or sit exactly one cycle apart, which makes both the lock and no-lock outcomes deterministic. Ratios with swallow values from 0 to 3 exercise every modulus mix, and the divider pulse counts seen on the test pin confirm the division exactly.

// File: rtl/intn_pkg.sv
package intn_pkg;
  typedef enum logic [1:0] {
    SRC_LOCK = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_REF  = 2'b10,
    SRC_LOW  = 2'b11
  } lock_src_e;
endpackage

// File: rtl/intn_ref_div.sv
module intn_ref_div #(
  parameter int R_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           ref_i,
  input  logic           dbl_en_i,
  input  logic [R_W-1:0] ratio_i,
  output logic           pls_o
);
  logic           ref_q;
  logic           tick;
  logic [R_W-1:0] cnt_q;

  assign tick = (ref_i & ~ref_q) | (dbl_en_i & ~ref_i & ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
      pls_o <= 1'b0;
    end else begin
      ref_q <= ref_i;
      if (restart_i) begin
        cnt_q <= '0;
        pls_o <= 1'b0;
      end else begin
        pls_o <= 1'b0;
        if (tick) begin
          if (cnt_q == ratio_i - R_W'(1)) begin
            cnt_q <= '0;
            pls_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + R_W'(1);
          end
        end
      end
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && ratio_i != '0) |-> cnt_q < ratio_i);
endmodule

// File: rtl/intn_main_div.sv
module intn_main_div #(
  parameter int N_W   = 16,
  parameter int PSC_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           osc_i,
  input  logic [N_W-1:0] ratio_i,
  output logic           pls_o
);
  localparam int P_W = N_W - PSC_W;
  localparam int M   = 1 << PSC_W;
  localparam logic [PSC_W:0] M_LAST = (PSC_W+1)'(M - 1);

  logic             osc_q, tick;
  logic [P_W-1:0]   p_fld;
  logic [PSC_W-1:0] a_fld;
  logic [PSC_W:0]   psc_q, psc_last;
  logic [P_W-1:0]   pc_q;
  logic [PSC_W-1:0] swc_q;
  logic             psc_out;

  assign p_fld    = ratio_i[N_W-1:PSC_W];
  assign a_fld    = ratio_i[PSC_W-1:0];
  assign tick     = osc_i & ~osc_q;
  // swallow phase: one extra oscillator edge per prescaler cycle
  assign psc_last = (swc_q < a_fld) ? M_LAST + (PSC_W+1)'(1) : M_LAST;
  assign psc_out  = tick && (psc_q == psc_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= 1'b0;
      psc_q <= '0;
      pc_q  <= '0;
      swc_q <= '0;
      pls_o <= 1'b0;
    end else begin
      osc_q <= osc_i;
      pls_o <= 1'b0;
      if (restart_i) begin
        psc_q <= '0;
        pc_q  <= '0;
        swc_q <= '0;
      end else if (tick) begin
        if (psc_out) begin
          psc_q <= '0;
          if (pc_q == p_fld - P_W'(1)) begin
            pc_q  <= '0;
            swc_q <= '0;
            pls_o <= 1'b1;
          end else begin
            pc_q <= pc_q + P_W'(1);
            if (swc_q < a_fld) swc_q <= swc_q + PSC_W'(1);
          end
        end else begin
          psc_q <= psc_q + (PSC_W+1)'(1);
        end
      end
    end
  end

  a_r1_swallow_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && p_fld > P_W'(a_fld)) |-> swc_q <= a_fld);
  a_r1_psc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_q <= M_LAST + (PSC_W+1)'(1));
endmodule

// File: rtl/intn_pfd.sv
module intn_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic ref_pls_i,
  input  logic main_pls_i,
  output logic up_o,
  output logic dn_o,
  output logic evt_o
);
  logic up_s, dn_s;

  assign up_s  = up_o | ref_pls_i;
  assign dn_s  = dn_o | main_pls_i;
  assign evt_o = up_s & dn_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else if (restart_i || evt_o) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_s;
      dn_o <= dn_s;
    end
  end

  a_r4_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
  a_r4_up_from_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |-> $past(ref_pls_i));
  a_r4_dn_from_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_o) |-> $past(main_pls_i));
endmodule

// File: rtl/intn_lock_det.sv
module intn_lock_det #(
  parameter int LOCK_CNT = 16,
  parameter int LOCK_WIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic evt_i,
  input  logic open_i,
  output logic locked_o
);
  localparam int W_W = $clog2(LOCK_WIN + 2);
  localparam int G_W = $clog2(LOCK_CNT + 1);
  localparam logic [G_W-1:0] G_LAST = G_W'(LOCK_CNT - 1);

  logic [W_W-1:0] wcnt_q, width_now;
  logic [G_W-1:0] good_q;
  logic           wide;

  assign width_now = wcnt_q + W_W'(open_i);
  assign wide      = width_now >= W_W'(LOCK_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q   <= '0;
      good_q   <= '0;
      locked_o <= 1'b0;
    end else if (restart_i) begin
      wcnt_q   <= '0;
      good_q   <= '0;
      locked_o <= 1'b0;
    end else begin
      if (evt_i) wcnt_q <= '0;
      else if (open_i && wcnt_q < W_W'(LOCK_WIN)) wcnt_q <= wcnt_q + W_W'(1);
      if (wide) begin
        good_q   <= '0;
        locked_o <= 1'b0;
      end else if (evt_i) begin
        if (good_q >= G_LAST) locked_o <= 1'b1;
        else good_q <= good_q + G_W'(1);
      end
    end
  end

  a_r5_rise_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(evt_i));
  a_r6_drop_on_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide && !restart_i) |=> !locked_o);
  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!locked_o && good_q == '0));
endmodule

// File: rtl/intn_div_lock.sv
module intn_div_lock #(
  parameter int N_W      = 16,
  parameter int R_W      = 9,
  parameter int PSC_W    = 6,
  parameter int LOCK_CNT = 16,
  parameter int LOCK_WIN = 8,
  parameter int N_RST    = 9750,
  parameter int R_RST    = 80
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_i,
  input  logic           osc_i,
  input  logic           dbl_en_i,
  input  logic [N_W-1:0] main_ratio_i,
  input  logic [R_W-1:0] ref_ratio_i,
  input  logic [1:0]     tst_sel_i,
  output logic           up_o,
  output logic           dn_o,
  output logic           lock_o
);
  import intn_pkg::*;

  logic [N_W-1:0] n_q;
  logic [R_W-1:0] r_q;
  logic           restart, ref_pls, main_pls, evt, locked;
  lock_src_e      src;
  logic           lock_d;

  assign restart = (main_ratio_i != n_q) || (ref_ratio_i != r_q);
  assign src     = lock_src_e'(tst_sel_i);

  always_comb begin
    unique case (src)
      SRC_LOCK: lock_d = locked;
      SRC_MAIN: lock_d = main_pls;
      SRC_REF:  lock_d = ref_pls;
      default:  lock_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= N_W'(N_RST);
      r_q    <= R_W'(R_RST);
      lock_o <= 1'b0;
    end else begin
      n_q    <= main_ratio_i;
      r_q    <= ref_ratio_i;
      lock_o <= lock_d;
    end
  end

  intn_ref_div #(.R_W(R_W)) u_ref_div (
    .clk_i, .rst_ni, .restart_i(restart), .ref_i, .dbl_en_i,
    .ratio_i(ref_ratio_i), .pls_o(ref_pls)
  );

  intn_main_div #(.N_W(N_W), .PSC_W(PSC_W)) u_main_div (
    .clk_i, .rst_ni, .restart_i(restart), .osc_i,
    .ratio_i(main_ratio_i), .pls_o(main_pls)
  );

  intn_pfd u_pfd (
    .clk_i, .rst_ni, .restart_i(restart), .ref_pls_i(ref_pls),
    .main_pls_i(main_pls), .up_o, .dn_o, .evt_o(evt)
  );

  intn_lock_det #(.LOCK_CNT(LOCK_CNT), .LOCK_WIN(LOCK_WIN)) u_lock (
    .clk_i, .rst_ni, .restart_i(restart), .evt_i(evt),
    .open_i(up_o | dn_o), .locked_o(locked)
  );

  a_r8_forced_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_sel_i == 2'b11) |=> !lock_o);
  a_r9_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!lock_o && !up_o && !dn_o));
endmodule

// File: tb/tb_intn_div_lock.sv
module tb_intn_div_lock;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // per vector: N, R, doubler, select, rises, expected (lock or pulse count), up/dn high cycles (-1 = skip)
  localparam int V_N  [NV] = '{12, 13, 13, 15, 12, 12, 13, 13, 14, 12, 14};
  localparam int V_R  [NV] = '{12, 12, 13, 15, 24, 23, 13, 10, 10, 12, 14};
  localparam int V_D  [NV] = '{ 0,  0,  0,  0,  1,  0,  0,  0,  1,  0,  0};
  localparam int V_S  [NV] = '{ 0,  0,  0,  0,  0,  0,  1,  2,  2,  3,  1};
  localparam int V_K  [NV] = '{400,400,400,400,400,400,260,250,250,400,280};
  localparam int V_E  [NV] = '{ 1,  0,  1,  1,  1,  0, 20, 25, 50,  0, 20};
  localparam int V_UP [NV] = '{ 0, -1,  0,  0,  0, -1, -1, -1, -1, -1, -1};
  localparam int V_DN [NV] = '{ 0, -1,  0,  0, 33, -1, -1, -1, -1, -1, -1};

  logic clk = 1'b0, rst_n = 1'b0, sig = 1'b0, dbl = 1'b0;
  logic [15:0] n_r = 16'd12;
  logic [8:0]  r_r = 9'd12;
  logic [1:0]  sel = 2'b00;
  logic up, dn, lock;
  int checks = 0, fails = 0;
  int hi_cnt, up_cnt, dn_cnt, both_cnt;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intn_div_lock #(.PSC_W(2), .LOCK_WIN(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(sig), .osc_i(sig), .dbl_en_i(dbl),
    .main_ratio_i(n_r), .ref_ratio_i(r_r), .tst_sel_i(sel),
    .up_o(up), .dn_o(dn), .lock_o(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v);
    sig = v;
    @(negedge clk);
    if (lock) hi_cnt++;
    if (up) up_cnt++;
    if (dn) dn_cnt++;
    if (up && dn) both_cnt++;
  endtask

  task automatic run(input int rises);
    for (int i = 0; i < rises; i++) begin
      cyc(1'b1);
      cyc(1'b0);
    end
    repeat (4) cyc(1'b0);
  endtask

  task automatic setup(input int n, input int r, input int d, input int s);
    n_r = 16'(n); r_r = 9'(r); dbl = d[0]; sel = 2'(s);
    repeat (3) cyc(1'b0);
    hi_cnt = 0; up_cnt = 0; dn_cnt = 0; both_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 lock_o in reset", int'(lock), 0);
    chk("R9 up/dn in reset", int'(up | dn), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 lock_o after reset", int'(lock), 0);

    for (int v = 0; v < NV; v++) begin
      setup(V_N[v], V_R[v], V_D[v], V_S[v]);
      run(V_K[v]);
      if (V_S[v] == 0)
        chk($sformatf("R1 R2 R3 R5 vector %0d lock", v), int'(lock), V_E[v]);
      else if (V_S[v] == 3)
        chk($sformatf("R8 vector %0d forced low", v), hi_cnt, V_E[v]);
      else
        chk($sformatf("R8 R1 R2 R3 vector %0d pulse count", v), hi_cnt, V_E[v]);
      chk($sformatf("R4 vector %0d up and dn together", v), both_cnt, 0);
      if (V_UP[v] >= 0) chk($sformatf("R4 vector %0d up cycles", v), up_cnt, V_UP[v]);
      if (V_DN[v] >= 0) chk($sformatf("R4 vector %0d dn cycles", v), dn_cnt, V_DN[v]);
    end

    // R5: fifteen good comparisons do not lock, the sixteenth does
    setup(12, 12, 0, 0);
    run(15 * 12);
    chk("R5 no lock after 15 comparisons", int'(lock), 0);
    run(2 * 12);
    chk("R5 lock after 16 comparisons", int'(lock), 1);

    // R6: doubling the reference without a ratio change breaks lock
    dbl = 1'b1;
    run(24);
    chk("R6 lock dropped on wide pulse", int'(lock), 0);

    // R7: ratio change clears lock within two cycles
    setup(13, 13, 0, 0);
    run(400);
    chk("R7 relock before change", int'(lock), 1);
    n_r = 16'd12;
    cyc(1'b0);
    cyc(1'b0);
    chk("R7 lock cleared by ratio change", int'(lock), 0);
    r_r = 9'd12;
    run(24);
    chk("R7 lock stays low after restart", int'(lock), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule